// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This unit sits next to a cache and watches the cache's demand misses. A miss that matches no stream claims one of several stream buffers. That buffer then requests the consecutive blocks that follow the missed block from memory. Memory answers arrive in any order. Each answer is written into the entry named by its tag.

A later miss whose block number equals the head entry of some stream is served from that buffer. The head moves into the cache through the fill port, and the next entry becomes the head. The freed entry then requests the block one past the stream's tail, so every stream stays full. A miss that matches no head is reported back as uncovered. It starts a new stream in the least recently used buffer, and any answers still in flight for that buffer's old blocks are thrown away.

Top module: `seq_stream_prefetcher`

## Requirements
- R1: After reset, `miss_ready` is 1, `fill_valid` is 0 and `pf_req_valid` is 0.
- R2: An accepted miss on block A that equals no stream head gives `fill_valid`=1, `fill_hit`=0 on the next cycle. The chosen stream then requests blocks A+1 to A+DEPTH, one request per cycle while `pf_req_ready` is high.
- R3: An accepted miss that equals a stream head whose data has arrived gives `fill_valid`=1, `fill_hit`=1, `fill_blk`=the block and `fill_data`=the data returned for it on the next cycle.
- R4: Each head consumed by a hit produces exactly one new request, for the block DEPTH above the consumed block (the old tail plus one). It uses the same stream and entry tag.
- R5: Only head entries are compared. A miss equal to a non-head entry of a stream is reported with `fill_hit`=0 and allocates a stream.
- R6: A miss equal to a head whose data has not arrived drops `miss_ready` and keeps `fill_valid` low until that data returns. It then fills with `fill_hit`=1, and no second request is issued for that entry.
- R7: Responses may come back in any order. Each response is stored in the entry named by its tag.
- R8: Allocation replaces the least recently used stream. A stream counts as used when a miss allocates it or hits its head. After reset the streams are taken in the order 0, 1, 2, ...
- R9: When a stream is replaced, any request still outstanding for one of its entries is discarded when its response arrives. That entry makes no new request until the discarded response has come back, and its new block is filled only from the new response.
- R10: `pf_req_tag` and `pf_rsp_tag` are {stream id, entry index}, with the stream id in the upper bits. On allocation for miss A, entry j holds block A+1+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache demand miss present |
| miss_ready | output | 1 | Miss accepted this cycle when high |
| miss_blk | input | ADDR_W | Block number of the miss |
| fill_valid | output | 1 | Result for an accepted miss |
| fill_hit | output | 1 | 1: data supplied by a stream; 0: not covered |
| fill_blk | output | ADDR_W | Block number of the result |
| fill_data | output | DATA_W | Block data when `fill_hit` is 1, else 0 |
| pf_req_valid | output | 1 | Prefetch request present |
| pf_req_ready | input | 1 | Memory accepts the request |
| pf_req_blk | output | ADDR_W | Block number to fetch |
| pf_req_tag | output | SID_W+SLOT_W | {stream id, entry index} |
| pf_rsp_valid | input | 1 | Prefetch data returning |
| pf_rsp_tag | input | SID_W+SLOT_W | Tag of the returning data |
| pf_rsp_data | input | DATA_W | Returned block data |

## Verification
The hardest case to reach is replacing a stream while some of its entries still wait for memory. The unit must then hold back new requests for those entries until the stale answers come back, and must drop those answers. The bench gets there by never answering three refill requests of stream 0. It then issues enough uncovered misses to make stream 0 the least recently used stream again. Next it returns the stale answer with the old block's data, and checks that the entry re-requests its new block only after that answer arrives. Finally, a hit on that block must return the fresh data, not the stale data.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic {
    PF_IDLE  = 1'b0,
    PF_STALL = 1'b1
  } pf_state_e;

  // block number k positions after base
  function automatic logic [63:0] blk_ahead(input logic [63:0] base, input int unsigned k);
    return base + 64'(k);
  endfunction

  // circular pointer advance over n slots
  function automatic int unsigned wrap_next(input int unsigned p, input int unsigned n);
    return (p + 1 == n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/pf_pick.sv
module pf_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pf_lru.sv
module pf_lru #(
  parameter int NS = 4,
  parameter int IW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_id_i,
  output logic [IW-1:0] victim_o
);
  logic [IW-1:0] age_q [NS];
  logic [NS-1:0] oldest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) age_q[i] <= IW'(NS - 1 - i);
    end else if (touch_i) begin
      for (int i = 0; i < NS; i++) begin
        if (touch_id_i == IW'(i)) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_id_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NS; i++) begin
      oldest[i] = (age_q[i] == IW'(NS - 1));
      if (oldest[i]) victim_o = IW'(i);
    end
  end

  p_single_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);
endmodule

// File: rtl/pf_stream.sv
module pf_stream #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int SW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic [AW-1:0] alloc_blk_i,
  input  logic          consume_i,
  input  logic [AW-1:0] look_blk_i,
  output logic          head_hit_o,
  output logic          head_rdy_o,
  output logic [DW-1:0] head_data_o,
  output logic          pend_o,
  output logic [SW-1:0] pend_slot_o,
  output logic [AW-1:0] pend_blk_o,
  input  logic          grant_i,
  input  logic          rsp_i,
  input  logic [SW-1:0] rsp_slot_i,
  input  logic [DW-1:0] rsp_data_i
);
  logic [SW-1:0]    head_q;
  logic [DEPTH-1:0] vld_w, iss_w, rdy_w, drop_w;
  logic [AW-1:0]    blk_w [DEPTH];
  logic [DW-1:0]    dat_w [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic          vld, iss, rdy, drop;
    logic [AW-1:0] blk;
    logic [DW-1:0] dat;
    logic          rsp_here, gnt_here, cons_here, busy_now;

    assign rsp_here  = rsp_i && (rsp_slot_i == SW'(j));
    assign gnt_here  = grant_i && pend_o && (pend_slot_o == SW'(j));
    assign cons_here = consume_i && (head_q == SW'(j));
    // a request for this entry is in memory after this cycle
    assign busy_now  = ((vld && iss && !rdy) || drop || gnt_here) && !rsp_here;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= 1'b0; iss <= 1'b0; rdy <= 1'b0; drop <= 1'b0;
        blk <= '0;   dat <= '0;
      end else if (alloc_i) begin
        vld  <= 1'b1; iss <= 1'b0; rdy <= 1'b0;
        drop <= busy_now;
        blk  <= AW'(pf_pkg::blk_ahead(64'(alloc_blk_i), unsigned'(j + 1)));
      end else if (cons_here) begin
        iss <= 1'b0; rdy <= 1'b0;
        blk <= AW'(pf_pkg::blk_ahead(64'(blk), DEPTH));
      end else begin
        if (gnt_here) iss <= 1'b1;
        if (rsp_here) begin
          if (drop) drop <= 1'b0;
          else if (vld && iss) begin
            rdy <= 1'b1;
            dat <= rsp_data_i;
          end
        end
      end
    end

    assign vld_w[j]  = vld;
    assign iss_w[j]  = iss;
    assign rdy_w[j]  = rdy;
    assign drop_w[j] = drop;
    assign blk_w[j]  = blk;
    assign dat_w[j]  = dat;

    p_rsp_has_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_here |-> ((vld && iss && !rdy) || drop));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head_q <= '0;
    else if (alloc_i) head_q <= '0;
    else if (consume_i) head_q <= SW'(pf_pkg::wrap_next(32'(head_q), DEPTH));
  end

  assign head_hit_o  = vld_w[head_q] && (blk_w[head_q] == look_blk_i);
  assign head_rdy_o  = rdy_w[head_q];
  assign head_data_o = dat_w[head_q];

  always_comb begin
    pend_o      = 1'b0;
    pend_slot_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_w[i] && !iss_w[i] && !drop_w[i]) begin
        pend_o      = 1'b1;
        pend_slot_o = SW'(i);
      end
    end
  end
  assign pend_blk_o = blk_w[pend_slot_o];
endmodule

// File: rtl/seq_stream_prefetcher.sv
module seq_stream_prefetcher #(
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  localparam int SID_W      = $clog2(NUM_STREAMS),
  localparam int SLOT_W     = $clog2(DEPTH),
  localparam int TAG_W      = SID_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_blk,
  output logic              fill_valid,
  output logic              fill_hit,
  output logic [ADDR_W-1:0] fill_blk,
  output logic [DATA_W-1:0] fill_data,
  output logic              pf_req_valid,
  input  logic              pf_req_ready,
  output logic [ADDR_W-1:0] pf_req_blk,
  output logic [TAG_W-1:0]  pf_req_tag,
  input  logic              pf_rsp_valid,
  input  logic [TAG_W-1:0]  pf_rsp_tag,
  input  logic [DATA_W-1:0] pf_rsp_data
);
  import pf_pkg::*;

  logic [NUM_STREAMS-1:0] hit_vec, rdy_vec, pend_vec;
  logic [NUM_STREAMS-1:0] alloc_vec, consume_vec, grant_vec, rsp_vec;
  logic [DATA_W-1:0]      head_data [NUM_STREAMS];
  logic [SLOT_W-1:0]      pend_slot [NUM_STREAMS];
  logic [ADDR_W-1:0]      pend_blk  [NUM_STREAMS];

  pf_state_e         state_q;
  logic [SID_W-1:0]  wait_sid_q;
  logic [ADDR_W-1:0] wait_blk_q;

  logic              hit_any;
  logic [SID_W-1:0]  hit_sid, req_sid, victim, cons_sid;
  logic [SID_W-1:0]  rsp_sid;
  logic [SLOT_W-1:0] rsp_slot;

  // named events
  logic miss_fire, ev_hit_now, ev_stall, ev_miss, ev_wake, cons_any;

  assign rsp_sid  = pf_rsp_tag[TAG_W-1:SLOT_W];
  assign rsp_slot = pf_rsp_tag[SLOT_W-1:0];

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
    assign alloc_vec[s]   = ev_miss && (victim == SID_W'(s));
    assign consume_vec[s] = cons_any && (cons_sid == SID_W'(s));
    assign grant_vec[s]   = pf_req_valid && pf_req_ready && (req_sid == SID_W'(s));
    assign rsp_vec[s]     = pf_rsp_valid && (rsp_sid == SID_W'(s));

    pf_stream #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W), .SW(SLOT_W)) u_stream (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_vec[s]),
      .alloc_blk_i (miss_blk),
      .consume_i   (consume_vec[s]),
      .look_blk_i  (miss_blk),
      .head_hit_o  (hit_vec[s]),
      .head_rdy_o  (rdy_vec[s]),
      .head_data_o (head_data[s]),
      .pend_o      (pend_vec[s]),
      .pend_slot_o (pend_slot[s]),
      .pend_blk_o  (pend_blk[s]),
      .grant_i     (grant_vec[s]),
      .rsp_i       (rsp_vec[s]),
      .rsp_slot_i  (rsp_slot),
      .rsp_data_i  (pf_rsp_data)
    );
  end

  pf_pick #(.N(NUM_STREAMS), .IW(SID_W)) u_hit_pick (
    .req_i (hit_vec), .any_o (hit_any), .idx_o (hit_sid));

  pf_pick #(.N(NUM_STREAMS), .IW(SID_W)) u_req_pick (
    .req_i (pend_vec), .any_o (pf_req_valid), .idx_o (req_sid));

  pf_lru #(.NS(NUM_STREAMS), .IW(SID_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_i    (miss_fire),
    .touch_id_i (hit_any ? hit_sid : victim),
    .victim_o   (victim));

  assign pf_req_blk = pend_blk[req_sid];
  assign pf_req_tag = {req_sid, pend_slot[req_sid]};

  assign miss_ready = (state_q == PF_IDLE);
  assign miss_fire  = miss_valid && miss_ready;
  assign ev_hit_now = miss_fire && hit_any && rdy_vec[hit_sid];
  assign ev_stall   = miss_fire && hit_any && !rdy_vec[hit_sid];
  assign ev_miss    = miss_fire && !hit_any;
  assign ev_wake    = (state_q == PF_STALL) && rdy_vec[wait_sid_q];
  assign cons_any   = ev_hit_now || ev_wake;
  assign cons_sid   = ev_wake ? wait_sid_q : hit_sid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PF_IDLE;
      wait_sid_q <= '0;
      wait_blk_q <= '0;
      fill_valid <= 1'b0;
      fill_hit   <= 1'b0;
      fill_blk   <= '0;
      fill_data  <= '0;
    end else begin
      fill_valid <= cons_any || ev_miss;
      fill_hit   <= cons_any;
      fill_blk   <= ev_wake ? wait_blk_q : miss_blk;
      fill_data  <= cons_any ? head_data[cons_sid] : '0;
      if (ev_stall) begin
        state_q    <= PF_STALL;
        wait_sid_q <= hit_sid;
        wait_blk_q <= miss_blk;
      end else if (ev_wake) begin
        state_q <= PF_IDLE;
      end
    end
  end

  p_accept_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> (fill_valid || state_q == PF_STALL));

  p_refill_after_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cons_any |=> pf_req_valid);

  p_wake_fills_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |=> (fill_valid && fill_hit && miss_ready));

  p_stall_holds_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PF_STALL && !rdy_vec[wait_sid_q]) |=> !fill_valid);
endmodule

// File: tb/seq_stream_prefetcher_bench.sv
`timescale 1ns/1ps
module seq_stream_prefetcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_blk = '0;
  logic        fill_valid, fill_hit;
  logic [31:0] fill_blk;
  logic [63:0] fill_data;
  logic        pf_req_valid;
  logic        pf_req_ready = 1'b1;
  logic [31:0] pf_req_blk;
  logic [3:0]  pf_req_tag;
  logic        pf_rsp_valid = 1'b0;
  logic [3:0]  pf_rsp_tag = '0;
  logic [63:0] pf_rsp_data = '0;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rec_blk [256];
  logic [3:0]  rec_tag [256];
  int n_rec = 0;

  always #4 clk = ~clk;

  seq_stream_prefetcher u_seq_stream_prefetcher (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_blk(miss_blk),
    .fill_valid(fill_valid), .fill_hit(fill_hit), .fill_blk(fill_blk), .fill_data(fill_data),
    .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready),
    .pf_req_blk(pf_req_blk), .pf_req_tag(pf_req_tag),
    .pf_rsp_valid(pf_rsp_valid), .pf_rsp_tag(pf_rsp_tag), .pf_rsp_data(pf_rsp_data));

  // request monitor: ready is tied high, so every sampled valid is one transfer
  always @(negedge clk) begin
    if (rst_n && pf_req_valid && n_rec < 256) begin
      rec_blk[n_rec] = pf_req_blk;
      rec_tag[n_rec] = pf_req_tag;
      n_rec++;
    end
  end

  function automatic logic [63:0] dval(input logic [31:0] b);
    return {~b, b};
  endfunction

  function automatic int count_req(input logic [31:0] b, input logic [3:0] t);
    int c = 0;
    for (int i = 0; i < n_rec; i++) if (rec_blk[i] == b && rec_tag[i] == t) c++;
    return c;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] b, input logic exp_hit, input string what);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_blk   = b;
    @(negedge clk);
    miss_valid = 1'b0;
    chk({what, " fill_valid"}, 64'(fill_valid), 64'd1);
    chk({what, " fill_hit"}, 64'(fill_hit), 64'(exp_hit));
    chk({what, " fill_blk"}, 64'(fill_blk), 64'(b));
    if (exp_hit) chk({what, " fill_data"}, fill_data, dval(b));
  endtask

  task automatic respond(input logic [3:0] t, input logic [63:0] d);
    @(negedge clk);
    pf_rsp_valid = 1'b1;
    pf_rsp_tag   = t;
    pf_rsp_data  = d;
    @(negedge clk);
    pf_rsp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 miss_ready", 64'(miss_ready), 64'd1);
    chk("R1 fill_valid", 64'(fill_valid), 64'd0);
    chk("R1 pf_req_valid", 64'(pf_req_valid), 64'd0);
  endtask

  // R2 R10: uncovered miss on 100 allocates stream 0 with 101..104
  task automatic t_first_alloc;
    lookup(32'd100, 1'b0, "R2 miss 100");
    idle(6);
    for (int j = 0; j < 4; j++)
      chk($sformatf("R10 req blk %0d tag %0d", 101 + j, j),
          64'(count_req(32'(101 + j), 4'(j))), 64'd1);
    chk("R2 request count", 64'(n_rec), 64'd4);
  endtask

  // R7 R3 R4: out-of-order answers, then head hits
  task automatic t_ooo_hits;
    respond(4'd3, dval(32'd104));
    respond(4'd1, dval(32'd102));
    respond(4'd0, dval(32'd101));
    respond(4'd2, dval(32'd103));
    lookup(32'd101, 1'b1, "R3 hit 101");
    idle(3);
    chk("R4 refill 105 tag 0", 64'(count_req(32'd105, 4'd0)), 64'd1);
    lookup(32'd102, 1'b1, "R7 hit 102");
    lookup(32'd103, 1'b1, "R7 hit 103");
    idle(3);
    chk("R4 refill 107 tag 2", 64'(count_req(32'd107, 4'd2)), 64'd1);
  endtask

  // R5: 106 sits behind head 104 of stream 0
  task automatic t_non_head;
    lookup(32'd106, 1'b0, "R5 non-head 106");
    idle(6);
    chk("R5 R8 stream 1 gets 107", 64'(count_req(32'd107, 4'd4)), 64'd1);
  endtask

  // R6: head 107 of stream 1 not yet answered
  task automatic t_stall;
    logic got;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_blk   = 32'd107;
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R6 no fill while waiting", 64'(fill_valid), 64'd0);
    chk("R6 miss_ready low", 64'(miss_ready), 64'd0);
    idle(3);
    chk("R6 still low", 64'(miss_ready), 64'd0);
    chk("R6 no reissue", 64'(count_req(32'd107, 4'd4)), 64'd1);
    respond(4'd4, dval(32'd107));
    got = 1'b0;
    for (int i = 0; i < 6 && !got; i++) begin
      @(negedge clk);
      if (fill_valid) begin
        got = 1'b1;
        chk("R6 fill_hit", 64'(fill_hit), 64'd1);
        chk("R6 fill_data", fill_data, dval(32'd107));
        chk("R6 fill_blk", 64'(fill_blk), 64'd107);
      end
    end
    chk("R6 fill arrived", 64'(got), 64'd1);
    chk("R6 miss_ready back", 64'(miss_ready), 64'd1);
  endtask

  // R8 R9: fill streams 2 and 3, then replace stream 0 with entries in flight
  task automatic t_replace;
    lookup(32'd200, 1'b0, "R8 miss 200");
    idle(6);
    chk("R8 stream 2 gets 201", 64'(count_req(32'd201, 4'd8)), 64'd1);
    lookup(32'd300, 1'b0, "R8 miss 300");
    idle(6);
    chk("R8 stream 3 gets 301", 64'(count_req(32'd301, 4'd12)), 64'd1);
    lookup(32'd400, 1'b0, "R8 miss 400");
    idle(6);
    chk("R8 stream 0 reused, 404 tag 3", 64'(count_req(32'd404, 4'd3)), 64'd1);
    chk("R9 401 held back", 64'(count_req(32'd401, 4'd0)), 64'd0);
    chk("R9 402 held back", 64'(count_req(32'd402, 4'd1)), 64'd0);
    chk("R9 403 held back", 64'(count_req(32'd403, 4'd2)), 64'd0);
    respond(4'd0, dval(32'd105));
    idle(4);
    chk("R9 401 requested after stale", 64'(count_req(32'd401, 4'd0)), 64'd1);
    respond(4'd0, dval(32'd401));
    idle(2);
    lookup(32'd401, 1'b1, "R9 fresh data 401");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_alloc;
    t_ooo_hits;
    t_non_head;
    t_stall;
    t_replace;
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule